// File: doc/BRIEF.md
# Block Address Window Translator

This block maps a 32-bit effective address onto a physical address through a small set of large, fixed-size address windows. It keeps two banks of window descriptors, one consulted by instruction fetches and one consulted by data accesses. Each bank holds `NUM_ENT` descriptor pairs. The first word of a pair, called the match word, says which region of effective addresses the window covers, how large the window is, and in which privilege levels it may be used. The second word, called the target word, gives the physical base of the window and its access rights.

A lookup is purely combinational. The caller presents the address, selects the instruction or data bank, gives the privilege level and says whether translation is on. In the same cycle the block returns a hit flag, the physical page address and read/write permission. When translation is off, the address passes through with full rights.

Descriptor words are loaded through a single-word write port with a 4-bit index. A write is captured on the rising clock edge, so it affects lookups from the following cycle on. The block has no state machine. Its only state is the descriptor storage, and reset clears that storage.

Top module: `blkmap_top`

## Requirements
- R1: `req_is_data`=0 searches only the instruction bank and `req_is_data`=1 searches only the data bank. An address mapped in one bank misses in the other.
- R2: A window can match only when effective-address bits 31:28 equal match-word bits 31:28 exactly.
- R3: Match-word bits 12:2 form a length mask for effective-address bits 27:17 (mask bit k covers address bit 17+k). Masked address bits are ignored by the comparison. The unmasked address bits must equal match-word bits 27:17. A match word with a set bit under its own mask can therefore never match.
- R4: In supervisor mode (`req_user`=0) a window is usable only if match-word bit 1 is set. In user mode (`req_user`=1) it is usable only if match-word bit 0 is set.
- R5: On a hit, the physical address is built as follows: bits 31:28 come from target-word bits 31:28; bits 27:17 are target-word bits 27:17 ORed with the masked effective-address bits; bits 16:12 are copied from the effective address; bits 11:0 are zero.
- R6: On a hit, the rights come from the target word. If target bit 1 is set, both read and write are granted. If only target bit 0 is set, read only is granted. If neither bit is set, no rights are granted, but the lookup is still a hit.
- R7: With `req_xlate_en`=0, the result is a hit with read and write granted and `rsp_pa` = effective address with bits 11:0 cleared, regardless of the stored descriptors.
- R8: When more than one usable window matches, the lowest-numbered entry supplies the result.
- R9: When no usable window matches, `rsp_hit`, `rsp_rd` and `rsp_wr` are 0 and `rsp_pa` is 0.
- R10: The write index is laid out as follows: bit 3 selects the bank (1 = data); bit 2 selects the word (1 = target word); bits 1:0 give the entry number. A write changes lookups only from the cycle after the capturing clock edge. Reset clears every word, so every translated lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Descriptor write enable |
| cfg_idx | input | 4 | Descriptor index {bank, word, entry} |
| cfg_wdata | input | 32 | Descriptor word to write |
| req_ea | input | 32 | Effective address |
| req_is_data | input | 1 | 0 = instruction bank, 1 = data bank |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| req_xlate_en | input | 1 | Translation enable for this access |
| rsp_hit | output | 1 | Translation found (or translation off) |
| rsp_pa | output | 32 | Physical page address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |

## Verification
The hardest case to reach from the ports is a lookup that falls through entries which match on address but are not usable. An example is a supervisor-only window, numbered below a user window that covers the same region, hit from user mode; the same shape arises with overlapping windows where only the lower-numbered one should win. The stimulus builds exactly this arrangement. The instruction bank holds a supervisor-only read-only window at entry 0 and a user-only read-write window at entry 2 over the same region. The data bank holds two identical-range windows with different targets. One vector table then probes both privilege levels and both banks. Directed tests follow: one checks that a target-word rewrite becomes visible only after its clock edge, and others check the cleared state after each reset.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;

    // Effective / physical address field boundaries
    localparam int ADDR_W      = 32;
    localparam int SEG_MSB     = 31;
    localparam int SEG_LSB     = 28;
    localparam int MID_MSB     = 27;
    localparam int MID_LSB     = 17;
    localparam int MID_W       = MID_MSB - MID_LSB + 1;
    localparam int PG_MSB      = 16;
    localparam int PG_LSB      = 12;
    localparam int OFS_W       = 12;

    // Match-word fields
    localparam int LEN_MSB     = 12;
    localparam int LEN_LSB     = 2;
    localparam int SUP_OK_BIT  = 1;
    localparam int USR_OK_BIT  = 0;

    // Target-word fields
    localparam int RIGHT_RW_BIT = 1;
    localparam int RIGHT_RO_BIT = 0;

    typedef enum logic {
        BANK_INSTR = 1'b0,
        BANK_DATA  = 1'b1
    } bank_e;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] pa;
        logic              rd;
        logic              wr;
    } xl_res_t;

endpackage

// File: rtl/blkmap_regs.sv
module blkmap_regs
    import blkmap_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int ENT_W  = $clog2(NUM_ENT),
    localparam int IDX_W  = ENT_W + 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [IDX_W-1:0]               idx,
    input  logic [ADDR_W-1:0]              wdata,
    input  logic                           bank_sel,
    output logic [NUM_ENT-1:0][ADDR_W-1:0] match_w,
    output logic [NUM_ENT-1:0][ADDR_W-1:0] target_w
);

    localparam int NUM_BANK = 2;

    logic [NUM_BANK-1:0][NUM_ENT-1:0][ADDR_W-1:0] match_q;
    logic [NUM_BANK-1:0][NUM_ENT-1:0][ADDR_W-1:0] target_q;

    logic              w_bank;
    logic              w_tgt;
    logic [ENT_W-1:0]  w_ent;

    assign w_bank = idx[IDX_W-1];
    assign w_tgt  = idx[IDX_W-2];
    assign w_ent  = idx[ENT_W-1:0];

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
            logic sel_here;
            assign sel_here = we && (w_bank == b[0]) && (w_ent == e[ENT_W-1:0]);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    match_q[b][e]  <= '0;
                    target_q[b][e] <= '0;
                end else if (sel_here) begin
                    if (w_tgt) begin
                        target_q[b][e] <= wdata;
                    end else begin
                        match_q[b][e]  <= wdata;
                    end
                end
            end
        end
    end

    always_comb begin
        match_w  = match_q[bank_sel];
        target_w = target_q[bank_sel];
    end

endmodule

// File: rtl/blkmap_cmp.sv
module blkmap_cmp
    import blkmap_pkg::*;
(
    input  logic [ADDR_W-1:0] ea,
    input  logic              user,
    input  logic [ADDR_W-1:0] match_word,
    input  logic [ADDR_W-1:0] target_word,
    output logic              usable_hit,
    output logic [ADDR_W-1:0] pa,
    output logic              rd,
    output logic              wr
);

    logic [MID_W-1:0] len_mask;
    logic             seg_eq;
    logic             mid_eq;
    logic             mode_ok;

    assign len_mask = match_word[LEN_MSB:LEN_LSB];
    assign seg_eq   = (ea[SEG_MSB:SEG_LSB] == match_word[SEG_MSB:SEG_LSB]);
    assign mid_eq   = ((ea[MID_MSB:MID_LSB] & ~len_mask) == match_word[MID_MSB:MID_LSB]);
    assign mode_ok  = user ? match_word[USR_OK_BIT] : match_word[SUP_OK_BIT];

    assign usable_hit = seg_eq && mid_eq && mode_ok;

    assign pa = {target_word[SEG_MSB:SEG_LSB],
                 (ea[MID_MSB:MID_LSB] & len_mask) | target_word[MID_MSB:MID_LSB],
                 ea[PG_MSB:PG_LSB],
                 {OFS_W{1'b0}}};

    assign wr = target_word[RIGHT_RW_BIT];
    assign rd = target_word[RIGHT_RW_BIT] | target_word[RIGHT_RO_BIT];

endmodule

// File: rtl/blkmap_pick.sv
module blkmap_pick
    import blkmap_pkg::*;
#(
    parameter int NUM_ENT = 4
) (
    input  logic [NUM_ENT-1:0]             hit_v,
    input  logic [NUM_ENT-1:0][ADDR_W-1:0] pa_v,
    input  logic [NUM_ENT-1:0]             rd_v,
    input  logic [NUM_ENT-1:0]             wr_v,
    output xl_res_t                        res
);

    // Walk from the highest entry down so the lowest match is written last.
    always_comb begin
        res = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (hit_v[i]) begin
                res.hit = 1'b1;
                res.pa  = pa_v[i];
                res.rd  = rd_v[i];
                res.wr  = wr_v[i];
            end
        end
    end

endmodule

// File: rtl/blkmap_top.sv
module blkmap_top
    import blkmap_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int IDX_W  = $clog2(NUM_ENT) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic [31:0]       req_ea,
    input  logic              req_is_data,
    input  logic              req_user,
    input  logic              req_xlate_en,
    output logic              rsp_hit,
    output logic [31:0]       rsp_pa,
    output logic              rsp_rd,
    output logic              rsp_wr
);

    logic [NUM_ENT-1:0][ADDR_W-1:0] match_w;
    logic [NUM_ENT-1:0][ADDR_W-1:0] target_w;
    logic [NUM_ENT-1:0]             hit_v;
    logic [NUM_ENT-1:0][ADDR_W-1:0] pa_v;
    logic [NUM_ENT-1:0]             rd_v;
    logic [NUM_ENT-1:0]             wr_v;
    xl_res_t                        win_res;
    xl_res_t                        out_res;

    blkmap_regs #(.NUM_ENT(NUM_ENT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .idx      (cfg_idx),
        .wdata    (cfg_wdata),
        .bank_sel (req_is_data),
        .match_w  (match_w),
        .target_w (target_w)
    );

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
        blkmap_cmp u_cmp (
            .ea          (req_ea),
            .user        (req_user),
            .match_word  (match_w[e]),
            .target_word (target_w[e]),
            .usable_hit  (hit_v[e]),
            .pa          (pa_v[e]),
            .rd          (rd_v[e]),
            .wr          (wr_v[e])
        );
    end

    blkmap_pick #(.NUM_ENT(NUM_ENT)) u_pick (
        .hit_v (hit_v),
        .pa_v  (pa_v),
        .rd_v  (rd_v),
        .wr_v  (wr_v),
        .res   (win_res)
    );

    always_comb begin
        if (!req_xlate_en) begin
            out_res.hit = 1'b1;
            out_res.pa  = {req_ea[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
            out_res.rd  = 1'b1;
            out_res.wr  = 1'b1;
        end else begin
            out_res = win_res;
        end
    end

    assign rsp_hit = out_res.hit;
    assign rsp_pa  = out_res.pa;
    assign rsp_rd  = out_res.rd;
    assign rsp_wr  = out_res.wr;

endmodule

// File: rtl/blkmap_chk.sv
module blkmap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] req_ea,
    input logic        req_xlate_en,
    input logic        rsp_hit,
    input logic [31:0] rsp_pa,
    input logic        rsp_rd,
    input logic        rsp_wr
);

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (!rsp_rd && !rsp_wr && rsp_pa == 32'h0)); // R9

    AST_BYPASS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !req_xlate_en |-> (rsp_hit && rsp_rd && rsp_wr)); // R7

    AST_BYPASS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !req_xlate_en |-> (rsp_pa == {req_ea[31:12], 12'h000})); // R7

    AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr |-> rsp_rd); // R6

    AST_PAGE_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_xlate_en && rsp_hit) |-> (rsp_pa[16:12] == req_ea[16:12] && rsp_pa[11:0] == 12'h000)); // R5

endmodule

bind blkmap_top blkmap_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ea       (req_ea),
    .req_xlate_en (req_xlate_en),
    .rsp_hit      (rsp_hit),
    .rsp_pa       (rsp_pa),
    .rsp_rd       (rsp_rd),
    .rsp_wr       (rsp_wr)
);

// File: tb/blkmap_top_tb.sv
module blkmap_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] req_ea = '0;
    logic        req_is_data = 1'b0;
    logic        req_user = 1'b0;
    logic        req_xlate_en = 1'b0;
    logic        rsp_hit;
    logic [31:0] rsp_pa;
    logic        rsp_rd;
    logic        rsp_wr;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    blkmap_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_idx      (cfg_idx),
        .cfg_wdata    (cfg_wdata),
        .req_ea       (req_ea),
        .req_is_data  (req_is_data),
        .req_user     (req_user),
        .req_xlate_en (req_xlate_en),
        .rsp_hit      (rsp_hit),
        .rsp_pa       (rsp_pa),
        .rsp_rd       (rsp_rd),
        .rsp_wr       (rsp_wr)
    );

    typedef struct packed {
        logic [31:0] ea;
        logic        dat;
        logic        usr;
        logic        en;
        logic        hit;
        logic [31:0] pa;
        logic        rd;
        logic        wr;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{32'h1000_5123, 1'b0, 1'b0, 1'b1, 1'b1, 32'h8000_5000, 1'b1, 1'b0}, // R5 R6 ro
        '{32'h1000_5123, 1'b0, 1'b1, 1'b1, 1'b1, 32'hA000_5000, 1'b1, 1'b1}, // R4 user skips entry0
        '{32'h2ABC_D123, 1'b0, 1'b0, 1'b1, 1'b1, 32'h9ABC_D000, 1'b1, 1'b1}, // R3 full mask
        '{32'h0ABC_D000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R2 nibble
        '{32'h3002_0000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R3 bit under mask
        '{32'h1002_0000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R3 unmasked bit
        '{32'h1000_2000, 1'b1, 1'b0, 1'b1, 1'b1, 32'hC000_2000, 1'b0, 1'b0}, // R1 R6 no rights
        '{32'h4006_1000, 1'b1, 1'b0, 1'b1, 1'b1, 32'hD006_1000, 1'b1, 1'b1}, // R8 R5 OR
        '{32'h4008_0000, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R3 beyond mask
        '{32'h5000_1000, 1'b1, 1'b1, 1'b1, 1'b1, 32'hF000_1000, 1'b1, 1'b1}, // R4 user ok
        '{32'h5000_1000, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R4 sup blocked
        '{32'h2ABC_D123, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R1 other bank
        '{32'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b1, 32'h1234_5000, 1'b1, 1'b1}, // R7
        '{32'h0000_0FFF, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 1'b1}, // R7
        '{32'h1000_2000, 1'b0, 1'b0, 1'b1, 1'b1, 32'h8000_2000, 1'b1, 1'b0}, // R1 instr bank
        '{32'h4000_0000, 1'b1, 1'b1, 1'b1, 1'b1, 32'hD000_0000, 1'b1, 1'b1}  // R8 user
    };

    task automatic apply(input logic [31:0] ea, input logic dat, input logic usr, input logic en);
        req_ea = ea;
        req_is_data = dat;
        req_user = usr;
        req_xlate_en = en;
    endtask

    task automatic expect_res(input string req, input logic hit, input logic [31:0] pa,
                              input logic rd, input logic wr);
        checks++;
        if (rsp_hit !== hit || rsp_pa !== pa || rsp_rd !== rd || rsp_wr !== wr) begin
            failures++;
            $display("FAIL %s ea=%h: got hit=%b pa=%h rd=%b wr=%b, expected hit=%b pa=%h rd=%b wr=%b",
                     req, req_ea, rsp_hit, rsp_pa, rsp_rd, rsp_wr, hit, pa, rd, wr);
        end
    endtask

    // idx = {bank(1=data), word(1=target), entry[1:0]}
    task automatic put(input logic [3:0] idx, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_idx = idx;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #(20 * 5000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state misses everywhere when translating
        apply(32'h1000_5123, 1'b0, 1'b0, 1'b1); #5;
        expect_res("R10 reset instr", 1'b0, 32'h0, 1'b0, 1'b0);
        apply(32'h0000_0000, 1'b1, 1'b1, 1'b1); #5;
        expect_res("R10 reset data", 1'b0, 32'h0, 1'b0, 1'b0);

        // instruction bank
        put(4'b0000, 32'h1000_0002); put(4'b0100, 32'h8000_0001);
        put(4'b0001, 32'h2000_1FFF); put(4'b0101, 32'h9000_0002);
        put(4'b0010, 32'h1000_0001); put(4'b0110, 32'hA000_0002);
        put(4'b0011, 32'h3002_0007); put(4'b0111, 32'hB000_0002);
        // data bank
        put(4'b1000, 32'h1000_0003); put(4'b1100, 32'hC000_0000);
        put(4'b1001, 32'h4000_000F); put(4'b1101, 32'hD000_0002);
        put(4'b1010, 32'h4000_000F); put(4'b1110, 32'hE000_0001);
        put(4'b1011, 32'h5000_0001); put(4'b1111, 32'hF000_0003);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i].ea, VEC[i].dat, VEC[i].usr, VEC[i].en);
            #5;
            expect_res($sformatf("R1-table vec%0d", i), VEC[i].hit, VEC[i].pa, VEC[i].rd, VEC[i].wr);
        end

        // R10: write visible only after its capturing edge
        @(negedge clk);
        apply(32'h5000_1000, 1'b1, 1'b1, 1'b1);
        cfg_we = 1'b1; cfg_idx = 4'b1111; cfg_wdata = 32'hF000_0001;
        #5;
        expect_res("R10 before edge", 1'b1, 32'hF000_1000, 1'b1, 1'b1);
        @(negedge clk);
        cfg_we = 1'b0;
        #5;
        expect_res("R10 after edge", 1'b1, 32'hF000_1000, 1'b1, 1'b0);

        // R8: clearing entry1 target exposes entry2 for the same window
        put(4'b1101, 32'h0000_0000);
        put(4'b1001, 32'h0000_0000);
        apply(32'h4006_1000, 1'b1, 1'b0, 1'b1); #5;
        expect_res("R8 next entry", 1'b1, 32'hE006_1000, 1'b1, 1'b0);

        // R10: reset clears stored words
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        apply(32'h2ABC_D123, 1'b0, 1'b0, 1'b1); #5;
        expect_res("R10 after reset", 1'b0, 32'h0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule